// File: doc/BRIEF.md
# Two-Port Hardware Semaphore Bank

This block holds a small set of token latches that two independent ports share so that software on each side can claim and hand back shared resources. Each port reaches the bank through its own select strobe while its memory enable is held inactive. The low index bits of the port's address pick a token. A write looks only at data bit 0: a 0 asks for the token and a 1 gives it back or withdraws a pending request. A read returns that port's own view of the token, 0 meaning "this port holds it" and 1 meaning "not mine", copied onto every data line.

Requests are kept in per-port latches. A request from the side that does not hold the token is remembered, and that side receives the token in the same edge at which the holder gives it up. Read results are taken into a per-port output register and stay there until the same port reads again, so a write from the other side cannot change a value while software is looking at it. Everything is synchronous to one clock; a write takes effect at the edge that samples it, and a read at the next edge already sees it.

Top module: `sema_bank`

## Requirements
- R1: The token is chosen by the low log2(NSEM) address bits (bits 2:0 with the default of eight tokens); higher address bits have no effect.
- R2: On a write only data bit 0 is used: 0 requests the token, 1 releases it or cancels a pending request; all other data bits are ignored.
- R3: When a port requests a free token, at the next edge that port reads 0 and the other port reads 1 at that index.
- R4: While one port holds a token, writes from the other port do not change who holds it.
- R5: If the non-holder has written 0 while the holder owns the token, the non-holder owns it from the edge at which the holder writes 1.
- R6: When the holder releases and the other side has no pending request, both ports read 1.
- R7: A legal read loads the port's view onto all DATA_W bits of its read register (all zeros or all ones); the register keeps that value until the same port makes another legal read.
- R8: An access counts only when the port's select is 1 and its memory enable is 0; with both at 1 the access is ignored.
- R9: After reset no token is owned, no request is pending, and both read registers hold all ones.
- R10: When both ports request the same free token in the same cycle, the left port gets it and the right port's request stays pending, so the right port gets the token when the left one releases.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| l_sel | input | 1 | Left port semaphore select, active high |
| l_mem_en | input | 1 | Left port memory enable; must be 0 for a semaphore access |
| l_we | input | 1 | Left port write (1) or read (0) |
| l_addr | input | ADDR_W | Left port address; low bits pick the token |
| l_wdata | input | DATA_W | Left port write data; bit 0 used |
| l_rdata | output | DATA_W | Left port captured read value |
| r_sel | input | 1 | Right port semaphore select, active high |
| r_mem_en | input | 1 | Right port memory enable; must be 0 for a semaphore access |
| r_we | input | 1 | Right port write (1) or read (0) |
| r_addr | input | ADDR_W | Right port address; low bits pick the token |
| r_wdata | input | DATA_W | Right port write data; bit 0 used |
| r_rdata | output | DATA_W | Right port captured read value |

## Verification
The bench builds the bank with its defaults: eight tokens, a 14-bit address and 18-bit data. The wide address lets it set upper address bits to prove they are ignored, and the 18-bit data lets it put ones on every bit but bit 0 to show that only bit 0 decides a write, and check that a read fills all eighteen lines. With eight tokens it can run the hand-over and tie sequences on separate indices and confirm that they do not disturb one another.

// File: rtl/sema_pkg.sv
package sema_pkg;
  typedef enum logic [1:0] {
    OWN_NONE  = 2'd0,
    OWN_LEFT  = 2'd1,
    OWN_RIGHT = 2'd2
  } owner_e;
endpackage

// File: rtl/sema_port_dec.sv
module sema_port_dec #(
  parameter int ADDR_W = 14,
  parameter int DATA_W = 18,
  parameter int IDX_W  = 3
) (
  input  logic              sel,
  input  logic              mem_en,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              acc_wr,
  output logic              acc_rd,
  output logic [IDX_W-1:0]  idx,
  output logic              bit0
);
  logic legal;

  always_comb begin
    legal  = sel && !mem_en;
    acc_wr = legal && we;
    acc_rd = legal && !we;
    idx    = addr[IDX_W-1:0];
    bit0   = wdata[0];
  end
endmodule

// File: rtl/sema_cell.sv
module sema_cell
  import sema_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic l_wr,
  input  logic l_bit,
  input  logic r_wr,
  input  logic r_bit,
  output logic l_view,
  output logic r_view
);
  logic   req_l, req_r, nreq_l, nreq_r;
  owner_e own, own_n;

  always_comb begin
    nreq_l = l_wr ? !l_bit : req_l;
    nreq_r = r_wr ? !r_bit : req_r;
    own_n  = own;
    unique case (own)
      OWN_LEFT:  own_n = nreq_l ? OWN_LEFT  : (nreq_r ? OWN_RIGHT : OWN_NONE);
      OWN_RIGHT: own_n = nreq_r ? OWN_RIGHT : (nreq_l ? OWN_LEFT  : OWN_NONE);
      default:   own_n = nreq_l ? OWN_LEFT  : (nreq_r ? OWN_RIGHT : OWN_NONE);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_l <= 1'b0;
      req_r <= 1'b0;
      own   <= OWN_NONE;
    end else begin
      req_l <= nreq_l;
      req_r <= nreq_r;
      own   <= own_n;
    end
  end

  assign l_view = (own != OWN_LEFT);
  assign r_view = (own != OWN_RIGHT);

  // R3
  take_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (own == OWN_NONE && l_wr && !l_bit) |=> (own == OWN_LEFT));

  // R4
  hold_left_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (own == OWN_LEFT && !(l_wr && l_bit)) |=> (own == OWN_LEFT));

  // R5
  handover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (own == OWN_LEFT && req_r && !(r_wr && r_bit) && l_wr && l_bit) |=> (own == OWN_RIGHT));

  // R6
  free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (own == OWN_RIGHT && !req_l && !(l_wr && !l_bit) && r_wr && r_bit) |=> (own == OWN_NONE));

  // R10
  tie_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (own == OWN_NONE && l_wr && !l_bit && r_wr && !r_bit) |=> (own == OWN_LEFT && req_r));
endmodule

// File: rtl/sema_bank.sv
module sema_bank #(
  parameter int ADDR_W = 14,
  parameter int DATA_W = 18,
  parameter int NSEM   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              l_sel,
  input  logic              l_mem_en,
  input  logic              l_we,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic [DATA_W-1:0] l_wdata,
  output logic [DATA_W-1:0] l_rdata,
  input  logic              r_sel,
  input  logic              r_mem_en,
  input  logic              r_we,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic [DATA_W-1:0] r_wdata,
  output logic [DATA_W-1:0] r_rdata
);
  localparam int IDX_W = (NSEM > 1) ? $clog2(NSEM) : 1;

  logic             l_wr, l_rd, l_bit, r_wr, r_rd, r_bit;
  logic [IDX_W-1:0] l_idx, r_idx;
  logic [NSEM-1:0]  l_view, r_view;

  sema_port_dec #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) l_dec_i (
    .sel(l_sel), .mem_en(l_mem_en), .we(l_we), .addr(l_addr), .wdata(l_wdata),
    .acc_wr(l_wr), .acc_rd(l_rd), .idx(l_idx), .bit0(l_bit)
  );

  sema_port_dec #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) r_dec_i (
    .sel(r_sel), .mem_en(r_mem_en), .we(r_we), .addr(r_addr), .wdata(r_wdata),
    .acc_wr(r_wr), .acc_rd(r_rd), .idx(r_idx), .bit0(r_bit)
  );

  for (genvar i = 0; i < NSEM; i++) begin : g_cell
    sema_cell cell_i (
      .clk   (clk),
      .rst_n (rst_n),
      .l_wr  (l_wr && (l_idx == IDX_W'(i))),
      .l_bit (l_bit),
      .r_wr  (r_wr && (r_idx == IDX_W'(i))),
      .r_bit (r_bit),
      .l_view(l_view[i]),
      .r_view(r_view[i])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      l_rdata <= '1;
      r_rdata <= '1;
    end else begin
      if (l_rd) l_rdata <= {DATA_W{l_view[l_idx]}};
      if (r_rd) r_rdata <= {DATA_W{r_view[r_idx]}};
    end
  end

  // R7
  l_rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !l_rd |=> $stable(l_rdata));

  // R7
  r_rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !r_rd |=> $stable(r_rdata));

  // R8
  l_illegal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (l_sel && l_mem_en) |=> $stable(l_rdata));
endmodule

// File: tb/sema_bank_tb_top.sv
module sema_bank_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 14;
  localparam int DATA_W = 18;
  localparam int NSEM   = 8;
  localparam logic [DATA_W-1:0] ONES  = '1;
  localparam logic [DATA_W-1:0] ZEROS = '0;

  // {l_wr, l_bit, r_wr, r_bit, idx[2:0], exp_l, exp_r}
  localparam int NVEC = 12;
  localparam logic [8:0] VEC [NVEC] = '{
    {1'b1,1'b0, 1'b0,1'b0, 3'd2, 1'b0,1'b1},  // R3 left takes free
    {1'b0,1'b0, 1'b1,1'b0, 3'd2, 1'b0,1'b1},  // R4 right request no effect
    {1'b1,1'b1, 1'b0,1'b0, 3'd2, 1'b1,1'b0},  // R5 hand-over to right
    {1'b1,1'b0, 1'b0,1'b0, 3'd2, 1'b1,1'b0},  // R4 left request pending
    {1'b0,1'b0, 1'b1,1'b1, 3'd2, 1'b0,1'b1},  // R5 hand-over to left
    {1'b1,1'b1, 1'b0,1'b0, 3'd2, 1'b1,1'b1},  // R6 freed
    {1'b0,1'b0, 1'b1,1'b0, 3'd2, 1'b1,1'b0},  // R3 right takes free
    {1'b0,1'b0, 1'b1,1'b1, 3'd2, 1'b1,1'b1},  // R6 freed
    {1'b1,1'b0, 1'b1,1'b0, 3'd5, 1'b0,1'b1},  // R10 tie left wins
    {1'b1,1'b1, 1'b0,1'b0, 3'd5, 1'b1,1'b0},  // R10 pending right served
    {1'b0,1'b0, 1'b1,1'b1, 3'd5, 1'b1,1'b1},  // R6 freed
    {1'b1,1'b1, 1'b0,1'b0, 3'd3, 1'b1,1'b1}   // R6 release of free token
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic l_sel = 0, l_mem_en = 0, l_we = 0;
  logic r_sel = 0, r_mem_en = 0, r_we = 0;
  logic [ADDR_W-1:0] l_addr = '0, r_addr = '0;
  logic [DATA_W-1:0] l_wdata = '0, r_wdata = '0;
  logic [DATA_W-1:0] l_rdata, r_rdata;
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sema_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NSEM(NSEM)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .l_sel(l_sel), .l_mem_en(l_mem_en), .l_we(l_we), .l_addr(l_addr),
    .l_wdata(l_wdata), .l_rdata(l_rdata),
    .r_sel(r_sel), .r_mem_en(r_mem_en), .r_we(r_we), .r_addr(r_addr),
    .r_wdata(r_wdata), .r_rdata(r_rdata)
  );

  task automatic check(input string req, input logic [DATA_W-1:0] act,
                       input logic [DATA_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    l_sel = 0; l_mem_en = 0; l_we = 0; l_wdata = '0; l_addr = '0;
    r_sel = 0; r_mem_en = 0; r_we = 0; r_wdata = '0; r_addr = '0;
  endtask

  task automatic tick();
    @(posedge clk); #1; idle();
  endtask

  task automatic read_both(input logic [ADDR_W-1:0] la, input logic [ADDR_W-1:0] ra);
    l_sel = 1; l_we = 0; l_addr = la;
    r_sel = 1; r_we = 0; r_addr = ra;
    tick();
  endtask

  initial begin
    #(CLK_PERIOD*20000);
    errors++; checks++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    idle();
    repeat (3) @(posedge clk);
    #1; rst_n = 1;
    // R9 reset state of registers, then every token reads free
    check("R9", l_rdata, ONES);
    check("R9", r_rdata, ONES);
    for (int i = 0; i < NSEM; i++) begin
      read_both(ADDR_W'(i), ADDR_W'(i));
      check("R9", l_rdata, ONES);
      check("R9", r_rdata, ONES);
    end

    for (int v = 0; v < NVEC; v++) begin
      l_sel = VEC[v][8]; l_we = VEC[v][8]; l_wdata = {DATA_W{VEC[v][7]}} ; l_addr = ADDR_W'(VEC[v][4:2]);
      r_sel = VEC[v][6]; r_we = VEC[v][6]; r_wdata = {DATA_W{VEC[v][5]}} ; r_addr = ADDR_W'(VEC[v][4:2]);
      tick();
      read_both(ADDR_W'(VEC[v][4:2]), ADDR_W'(VEC[v][4:2]));
      check($sformatf("R3/R4/R5/R6/R10 vec%0d L", v), l_rdata, VEC[v][1] ? ONES : ZEROS);
      check($sformatf("R3/R4/R5/R6/R10 vec%0d R", v), r_rdata, VEC[v][0] ? ONES : ZEROS);
    end

    // R1: upper address bits ignored
    l_sel = 1; l_we = 1; l_addr = 14'h2A4; l_wdata = '0; tick();
    read_both(14'h1004, 14'h3FFC);
    check("R1", l_rdata, ZEROS);
    check("R1", r_rdata, ONES);

    // R2: only bit 0 decides; ones elsewhere still request
    r_sel = 1; r_we = 1; r_addr = 14'd1; r_wdata = 18'h3FFFE; tick();
    read_both(14'd1, 14'd1);
    check("R2", r_rdata, ZEROS);
    r_sel = 1; r_we = 1; r_addr = 14'd1; r_wdata = 18'h00001; tick();
    read_both(14'd1, 14'd1);
    check("R2", r_rdata, ONES);
    check("R2", l_rdata, ONES);

    // R8: select together with memory enable is ignored (write and read)
    l_sel = 1; l_mem_en = 1; l_we = 1; l_addr = 14'd7; l_wdata = '0; tick();
    read_both(14'd7, 14'd7);
    check("R8", l_rdata, ONES);
    read_both(14'd4, 14'd4);  // left owns 4 -> left reads zeros
    l_sel = 1; l_mem_en = 1; l_we = 0; l_addr = 14'd7; tick();
    check("R8", l_rdata, ZEROS);

    // R7: captured value holds while the token changes
    l_sel = 1; l_we = 1; l_addr = 14'd6; l_wdata = '0; tick();
    read_both(14'd6, 14'd6);
    check("R7", l_rdata, ZEROS);
    l_sel = 1; l_we = 1; l_addr = 14'd6; l_wdata = 18'h1;
    r_sel = 1; r_we = 1; r_addr = 14'd6; r_wdata = '0; tick();
    tick();
    check("R7", l_rdata, ZEROS);
    check("R7", r_rdata, ONES);
    read_both(14'd6, 14'd6);
    check("R7", l_rdata, ONES);
    check("R7", r_rdata, ZEROS);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule